// File: doc/BRIEF.md
# Circular Trace Capture Controller

This block sits between a processor trace port and an external sample memory. It packs the 4-bit trace packet, the 3-bit pipeline status and the sync flag of every accepted trace cycle into one byte. It issues one memory write per byte. The write address is a frame number joined to a slot number, with sixteen samples per frame. The frame number runs around a power-of-two buffer, 1048576 frames by default. When it wraps, a sticky full flag is raised, and the frame register then names the oldest frame still held.

The block runs on a capture clock at twice the trace clock rate. A one-cycle strobe, `trc_stb`, marks each rising edge of the trace clock. In full-rate mode only the strobed cycles are sampled. In half-rate mode every capture clock cycle is sampled, which takes the port on both trace clock edges.

Host software starts a run in three steps: it presets the frame register, loads a post-trigger frame count, and then writes the enable bit. A trigger status code in the sample stream starts the countdown, which steps once per completed frame. When the count runs out, the run is marked complete and writing stops. A trace clock lock indication from an external PLL is passed through as a status bit.

Top module: `trace_capture_ctrl`

## Requirements
- R1: Each accepted sample is written one cycle after the capture edge that accepted it. `mem_we` is high, and `mem_data` holds the sync flag in bit 7, the packet in bits 6:3 and the pipeline status in bits 2:0. `mem_addr` is the current frame number in the upper bits and the slot (0 to 15) in the low 4 bits.
- R2: The control register is written with `reg_sel` = 2. Bit 0 enables capture and bit 1 selects half-rate mode. With bit 1 clear, a sample is accepted only in a cycle where `trc_stb` is high.
- R3: With control bit 1 set, a sample is accepted in every enabled cycle, whatever the value of `trc_stb`.
- R4: An accepted sample whose pipeline status is 3'b110 is a trigger. It sets `stat_trig`, which stays set until the next control write with bit 0 set. The byte is stored unchanged.
- R5: The post-trigger count is loaded with `reg_sel` = 1, as a number of frames. The frame that holds the trigger counts as the first. `stat_done` rises when the last counted frame completes, and a count of 0 acts as 1. While `stat_done` is set, no sample is written.
- R6: The frame register is loaded with `reg_sel` = 0, which also resets the slot to 0. `frame_addr` is the frame to be written next. It advances by one after every sixteenth accepted sample.
- R7: When a frame completes at the last frame number, the frame number wraps to 0 and `stat_full` is set. `stat_full` stays set until the next control write with bit 0 set.
- R8: A control write with bit 0 clear stops capture. The capture edge of the write may still store one sample, but the following edges store none. `stat_trig` and `stat_full` keep their values.
- R9: `stat_lock` is `pll_locked` delayed by one clock.
- R10: After a synchronous reset, `mem_we`, `frame_addr`, `stat_done`, `stat_trig`, `stat_full` and `stat_lock` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, twice the trace clock rate |
| rst | input | 1 | Synchronous active-high reset |
| trc_stb | input | 1 | High in cycles that coincide with a trace clock rising edge |
| trc_pkt | input | 4 | Trace packet nibble |
| trc_stat | input | 3 | Pipeline status code |
| trc_sync | input | 1 | Trace sync flag |
| pll_locked | input | 1 | Trace clock PLL lock indication |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 frame, 1 post-trigger count, 2 control |
| reg_wdata | input | 32 | Register write data |
| mem_we | output | 1 | Sample memory write enable |
| mem_addr | output | FRAME_AW+4 | Sample memory byte address: frame and slot |
| mem_data | output | 8 | Packed sample byte |
| frame_addr | output | FRAME_AW | Next frame to be written |
| stat_done | output | 1 | Post-trigger countdown expired |
| stat_trig | output | 1 | Trigger seen in this run |
| stat_full | output | 1 | Buffer has wrapped in this run |
| stat_lock | output | 1 | Registered PLL lock |

## Verification
The memory write port is registered. A sample accepted at one edge therefore appears on `mem_we`, `mem_addr` and `mem_data` after that edge. The status flags and `frame_addr` change at the same edge as the sample that causes them, and `stat_lock` trails `pll_locked` by exactly one edge. The bench drives inputs at a falling edge, lets one rising edge pass and reads the ports at the next falling edge, so every check sees the result of exactly one capture edge. The halt case reads `mem_we` only from the second edge after the control write, and the post-trigger case reads `stat_done` both one sample before and at the final sample of the counted frames.

// File: rtl/trc_cap_pkg.sv
package trc_cap_pkg;
  localparam logic [2:0] SEL_FRAME  = 3'd0;
  localparam logic [2:0] SEL_TCOUNT = 3'd1;
  localparam logic [2:0] SEL_CTRL   = 3'd2;

  localparam logic [2:0] TRIG_STAT  = 3'b110;

  typedef struct packed {
    logic       sync;
    logic [3:0] pkt;
    logic [2:0] stat;
  } trc_sample_t;
endpackage

// File: rtl/trc_sample_gate.sv
module trc_sample_gate (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic wr_en_bit,
  input  logic wr_half_bit,
  input  logic trc_stb,
  input  logic done,
  output logic start,
  output logic take
);
  logic en_q;
  logic half_q;

  assign start = ctrl_wr & wr_en_bit;
  assign take  = en_q & ~done & (half_q | trc_stb);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      half_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q   <= wr_en_bit;
      half_q <= wr_half_bit;
    end
  end
endmodule

// File: rtl/trc_frame_ptr.sv
module trc_frame_ptr #(
  parameter int FRAME_AW = 20,
  parameter int SLOT_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                ld_frame,
  input  logic [FRAME_AW-1:0] ld_val,
  input  logic                take,
  output logic [FRAME_AW-1:0] frame_q,
  output logic [SLOT_W-1:0]   slot_q,
  output logic                frame_end,
  output logic                full_q
);
  localparam logic [SLOT_W-1:0]   SLOT_LAST  = '1;
  localparam logic [FRAME_AW-1:0] FRAME_LAST = '1;

  assign frame_end = take & (slot_q == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      slot_q  <= '0;
    end else if (ld_frame) begin
      frame_q <= ld_val;
      slot_q  <= '0;
    end else if (start) begin
      slot_q  <= '0;
    end else if (take) begin
      slot_q <= slot_q + 1'b1;
      if (frame_end) frame_q <= frame_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start)
      full_q <= 1'b0;
    else if (!ld_frame && frame_end && frame_q == FRAME_LAST)
      full_q <= 1'b1;
  end
endmodule

// File: rtl/trc_post_trigger.sv
module trc_post_trigger #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ld_cnt,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             take,
  input  logic             is_trig,
  input  logic             frame_end,
  output logic             trig_q,
  output logic             done_q
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed;
  logic             last_frame;

  assign armed      = trig_q | (take & is_trig);
  assign last_frame = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (ld_cnt)
      cnt_q <= ld_val;
    else if (frame_end && armed && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      trig_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (take && is_trig) trig_q <= 1'b1;
      if (frame_end && armed && last_frame) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl #(
  parameter int FRAME_AW  = 20,
  parameter int FRAME_LEN = 16,
  localparam int SLOT_W   = $clog2(FRAME_LEN),
  localparam int CNT_W    = FRAME_AW + 1,
  localparam int MADDR_W  = FRAME_AW + SLOT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trc_stb,
  input  logic [3:0]          trc_pkt,
  input  logic [2:0]          trc_stat,
  input  logic                trc_sync,
  input  logic                pll_locked,
  input  logic                reg_we,
  input  logic [2:0]          reg_sel,
  input  logic [31:0]         reg_wdata,
  output logic                mem_we,
  output logic [MADDR_W-1:0]  mem_addr,
  output logic [7:0]          mem_data,
  output logic [FRAME_AW-1:0] frame_addr,
  output logic                stat_done,
  output logic                stat_trig,
  output logic                stat_full,
  output logic                stat_lock
);
  import trc_cap_pkg::*;

  logic ctrl_wr, frame_wr, cnt_wr;
  logic start, take, frame_end, is_trig;
  logic [SLOT_W-1:0] slot;
  trc_sample_t smp;
  logic unused_wdata;

  assign ctrl_wr  = reg_we && reg_sel == SEL_CTRL;
  assign frame_wr = reg_we && reg_sel == SEL_FRAME;
  assign cnt_wr   = reg_we && reg_sel == SEL_TCOUNT;
  assign unused_wdata = ^reg_wdata[31:CNT_W];

  assign smp.sync = trc_sync;
  assign smp.pkt  = trc_pkt;
  assign smp.stat = trc_stat;
  assign is_trig  = (trc_stat == TRIG_STAT);

  trc_sample_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .ctrl_wr     (ctrl_wr),
    .wr_en_bit   (reg_wdata[0]),
    .wr_half_bit (reg_wdata[1]),
    .trc_stb     (trc_stb),
    .done        (stat_done),
    .start       (start),
    .take        (take)
  );

  trc_frame_ptr #(.FRAME_AW(FRAME_AW), .SLOT_W(SLOT_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ld_frame  (frame_wr),
    .ld_val    (reg_wdata[FRAME_AW-1:0]),
    .take      (take),
    .frame_q   (frame_addr),
    .slot_q    (slot),
    .frame_end (frame_end),
    .full_q    (stat_full)
  );

  trc_post_trigger #(.CNT_W(CNT_W)) u_post (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ld_cnt    (cnt_wr),
    .ld_val    (reg_wdata[CNT_W-1:0]),
    .take      (take),
    .is_trig   (is_trig),
    .frame_end (frame_end),
    .trig_q    (stat_trig),
    .done_q    (stat_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      stat_lock <= 1'b0;
    end else begin
      mem_we    <= take;
      stat_lock <= pll_locked;
      if (take) begin
        mem_addr <= {frame_addr, slot};
        mem_data <= smp;
      end
    end
  end
endmodule

// File: rtl/trc_cap_checker.sv
module trc_cap_checker (
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic [2:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic        pll_locked,
  input logic        mem_we,
  input logic        stat_done,
  input logic        stat_trig,
  input logic        stat_full,
  input logic        stat_lock
);
  logic ctrl_wr, start_wr, halt_wr, unused_hi;
  assign ctrl_wr  = reg_we && reg_sel == 3'd2;
  assign start_wr = ctrl_wr && reg_wdata[0];
  assign halt_wr  = ctrl_wr && !reg_wdata[0];
  assign unused_hi = ^reg_wdata[31:1];

  assert_no_write_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    stat_done |=> !mem_we);

  assert_done_needs_trigger_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_done) |-> stat_trig);

  assert_trig_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (stat_trig && !start_wr) |=> stat_trig);

  assert_full_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_full && !start_wr) |=> stat_full);

  assert_halt_stops_R8: assert property (@(posedge clk) disable iff (rst)
    halt_wr |=> ##1 !mem_we);

  assert_lock_delay_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (stat_lock == $past(pll_locked)));
endmodule

bind trace_capture_ctrl trc_cap_checker u_chk (.*);

// File: tb/sim_trace_capture_ctrl.sv
`timescale 1ns/1ps
module sim_trace_capture_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trc_stb = 1'b0;
  logic [3:0]  trc_pkt = '0;
  logic [2:0]  trc_stat = '0;
  logic        trc_sync = 1'b0;
  logic        pll_locked = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data;
  logic [19:0] frame_addr;
  logic        stat_done, stat_trig, stat_full, stat_lock;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  trace_capture_ctrl u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] sel, logic [31:0] val);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send(logic stb, logic [3:0] pkt, logic [2:0] st, logic sy);
    trc_stb = stb; trc_pkt = pkt; trc_stat = st; trc_sync = sy;
    @(posedge clk); @(negedge clk);
    trc_stb = 1'b0; trc_pkt = '0; trc_stat = '0; trc_sync = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 mem_we", mem_we, 0);
    check("R10 frame_addr", frame_addr, 0);
    check("R10 flags", {stat_done, stat_trig, stat_full, stat_lock}, 0);
  endtask

  task automatic t_lock();
    pll_locked = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 lock high", stat_lock, 1);
    pll_locked = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 lock low", stat_lock, 0);
  endtask

  task automatic t_full_rate_and_trigger();
    wr_reg(3'd0, 0);
    wr_reg(3'd1, 2);
    wr_reg(3'd2, 1);
    send(1'b0, 4'hA, 3'd3, 1'b1);
    check("R2 no strobe no write", mem_we, 0);
    send(1'b1, 4'hA, 3'd3, 1'b1);
    check("R1 we", mem_we, 1);
    check("R1 data", mem_data, 8'hD3);
    check("R1 addr", mem_addr, 0);
    for (int i = 1; i < 16; i++) send(1'b1, 4'h1, 3'd0, 1'b0);
    check("R1 last slot addr", mem_addr, 24'h00000F);
    check("R6 frame after 16", frame_addr, 1);
    for (int i = 0; i < 5; i++) send(1'b1, 4'h2, 3'd1, 1'b0);
    check("R4 no trig yet", stat_trig, 0);
    send(1'b1, 4'b0101, 3'b110, 1'b0);
    check("R4 trig set", stat_trig, 1);
    check("R4 raw byte", mem_data, 8'h2E);
    check("R1 trig addr", mem_addr, 24'h000015);
    for (int i = 0; i < 10; i++) send(1'b1, 4'h3, 3'd0, 1'b0);
    check("R5 not done after first frame", stat_done, 0);
    check("R6 frame 2", frame_addr, 2);
    for (int i = 0; i < 15; i++) send(1'b1, 4'h3, 3'd0, 1'b0);
    check("R5 not done one sample early", stat_done, 0);
    send(1'b1, 4'h3, 3'd0, 1'b0);
    check("R5 done", stat_done, 1);
    check("R6 frame 3", frame_addr, 3);
    send(1'b1, 4'h3, 3'd0, 1'b0);
    check("R5 no write after done", mem_we, 0);
    check("R5 frame kept", frame_addr, 3);
  endtask

  task automatic t_half_and_halt();
    wr_reg(3'd0, 0);
    wr_reg(3'd1, 5);
    wr_reg(3'd2, 3);
    check("R4 trig cleared by enable", stat_trig, 0);
    check("R5 done cleared by enable", stat_done, 0);
    send(1'b0, 4'h7, 3'd2, 1'b0);
    check("R3 write without strobe", mem_we, 1);
    check("R3 data", mem_data, 8'h3A);
    send(1'b0, 4'h0, 3'b110, 1'b0);
    check("R4 trig half", stat_trig, 1);
    check("R3 slot 1", mem_addr, 24'h000001);
    wr_reg(3'd2, 0);
    send(1'b1, 4'h1, 3'd0, 1'b0);
    check("R8 halted", mem_we, 0);
    check("R8 trig kept", stat_trig, 1);
    check("R8 done stays low", stat_done, 0);
  endtask

  task automatic t_wrap();
    wr_reg(3'd0, 32'h000F_FFFF);
    wr_reg(3'd1, 100);
    wr_reg(3'd2, 1);
    check("R7 full clear", stat_full, 0);
    send(1'b1, 4'h4, 3'd0, 1'b0);
    check("R6 preset addr", mem_addr, 24'hFFFFF0);
    for (int i = 1; i < 16; i++) send(1'b1, 4'h4, 3'd0, 1'b0);
    check("R7 wrapped frame", frame_addr, 0);
    check("R7 full set", stat_full, 1);
    wr_reg(3'd2, 0);
    check("R8 full kept", stat_full, 1);
    wr_reg(3'd2, 1);
    check("R7 full cleared", stat_full, 0);
  endtask

  task automatic t_count_zero();
    wr_reg(3'd0, 0);
    wr_reg(3'd1, 0);
    wr_reg(3'd2, 1);
    send(1'b1, 4'h0, 3'b110, 1'b0);
    for (int i = 1; i < 15; i++) send(1'b1, 4'h1, 3'd0, 1'b0);
    check("R5 count0 early", stat_done, 0);
    send(1'b1, 4'h1, 3'd0, 1'b0);
    check("R5 count0 done", stat_done, 1);
    check("R6 count0 frame", frame_addr, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lock();
    t_full_rate_and_trigger();
    t_half_and_halt();
    t_wrap();
    t_count_zero();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule